// File: doc/BRIEF.md
# Indexed Read-Modify-Write Bus Sequencer

This block produces the cycle-by-cycle bus activity of an 8-bit processor as it runs one read-modify-write instruction with absolute addressing indexed by X. It fetches the opcode and the two address bytes. It adds the index to the low byte and reads once from the address with no carry applied. It then reads the real operand and writes it back unchanged. Last, it writes the modified value. The program counter, the flags and a completion pulse are updated along the way.

Before the first cycle the sequencer is idle, and its address output shows the program counter. An instruction starts when `start` is high during an idle cycle. That cycle is bus cycle 1, the opcode fetch. The following six cycles are generated internally. The cycle after the completion pulse is idle again and shows the next opcode address, which makes it bus cycle 8. Memory is read combinationally: `rdata` must carry the byte at `addr` before the end of the same cycle.

Top module: `rmw_absx_seq`

## Requirements
- R1: After reset, `addr` and `pc` equal the parameter `RESET_PC`. `we`, `done`, `flag_n`, `flag_z` and `flag_c` are all 0.
- R2: Cycles 1, 2 and 3 are reads at PC, PC+1 and PC+2. The byte read in cycle 2 is the low address byte, and the byte read in cycle 3 is the high address byte.
- R3: Cycle 4 is a read at {high, (low+X) mod 256}, with no carry applied. This holds whether or not the sum overflowed, and the byte read there has no effect on any later write or flag.
- R4: Cycles 5, 6 and 7 all use the address {(high+carry) mod 256, (low+X) mod 256}, where carry is bit 8 of low+X.
- R5: `we` is 1 only in cycles 6 and 7. In cycle 6, `wdata` is the operand read in cycle 5, unmodified. In cycle 7, `wdata` is the result.
- R6: The `op_sel` encoding gives the result r from operand v and carry c as follows: 0 → v<<1; 1 → v>>1; 2 → {v[6:0],c}; 3 → {c,v[7:1]}; 4 → v+1; 5 → v−1 (both modulo 256); 6 and 7 → v unchanged.
- R7: After the instruction, `flag_n` = r[7] and `flag_z` = (r==0). `flag_c` = v[7] for codes 0 and 2, and v[0] for codes 1 and 3. For the other codes, `flag_c` equals the sampled `c_in`.
- R8: `done` is 1 only in cycle 7. The new flags are visible from cycle 8.
- R9: In cycle 8, `addr` and `pc` both equal the starting PC + 3 (mod 65536).
- R10: `start` has no effect while an instruction is in progress (cycles 2 through 7).
- R11: `op_sel`, `x_idx` and `c_in` are sampled in cycle 1. Changes to them in cycles 2 through 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an instruction when high in an idle cycle |
| op_sel | input | 3 | Operation code, see R6 |
| x_idx | input | 8 | Index register value |
| c_in | input | 1 | Carry flag before the instruction |
| rdata | input | 8 | Read data bus |
| addr | output | 16 | Address bus |
| we | output | 1 | Write strobe |
| wdata | output | 8 | Write data bus |
| pc | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | High in the last bus cycle of the instruction |

## Verification
Some properties hold on every cycle and are checked by the assertions. Writes always come as a back-to-back pair. The first write of the pair returns the byte read just before it. The address does not change across the reads and writes to the corrected location. The completion pulse is single and comes with the final write. The program counter has advanced by exactly three when that pulse appears.

Other behaviour is shown only by the bench's scenarios, because they require expected values computed from chosen inputs. These are the exact dummy-read address with and without a page crossing and with wrap of the high byte. They also include the result and flags of each operation code at the operand corners. Finally, the bench shows that a start request, or changed operation inputs, arriving mid-instruction are ignored.

// File: rtl/rmw_absx_seq.sv
module rmw_absx_seq #(
  parameter logic [15:0] RESET_PC = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_sel,
  input  logic [7:0]  x_idx,
  input  logic        c_in,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        we,
  output logic [7:0]  wdata,
  output logic [15:0] pc,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        done
);

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_DUMMY, S_READ, S_WBACK, S_WRITE
  } phase_t;

  phase_t      state;
  logic [15:0] pc_q;
  logic [7:0]  lo_q, hi_q, x_q, opnd_q, res_q;
  logic [2:0]  op_q;
  logic        cin_q, fix_q, res_c_q;
  logic [7:0]  alu_v;
  logic        alu_c;

  always_comb begin
    alu_v = opnd_q;
    alu_c = cin_q;
    case (op_q)
      3'd0: begin alu_v = {opnd_q[6:0], 1'b0};  alu_c = opnd_q[7]; end
      3'd1: begin alu_v = {1'b0, opnd_q[7:1]};  alu_c = opnd_q[0]; end
      3'd2: begin alu_v = {opnd_q[6:0], cin_q}; alu_c = opnd_q[7]; end
      3'd3: begin alu_v = {cin_q, opnd_q[7:1]}; alu_c = opnd_q[0]; end
      3'd4: alu_v = opnd_q + 8'd1;
      3'd5: alu_v = opnd_q - 8'd1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc_q    <= RESET_PC;
      lo_q    <= '0;
      hi_q    <= '0;
      x_q     <= '0;
      op_q    <= '0;
      cin_q   <= 1'b0;
      fix_q   <= 1'b0;
      opnd_q  <= '0;
      res_q   <= '0;
      res_c_q <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc_q  <= pc_q + 16'd1;
          op_q  <= op_sel;
          x_q   <= x_idx;
          cin_q <= c_in;
          state <= S_LO;
        end
        S_LO: begin
          lo_q  <= rdata;
          pc_q  <= pc_q + 16'd1;
          state <= S_HI;
        end
        S_HI: begin
          {fix_q, lo_q} <= {1'b0, lo_q} + {1'b0, x_q};
          hi_q  <= rdata;
          pc_q  <= pc_q + 16'd1;
          state <= S_DUMMY;
        end
        S_DUMMY: begin
          hi_q  <= hi_q + {7'd0, fix_q};
          state <= S_READ;
        end
        S_READ: begin
          opnd_q <= rdata;
          state  <= S_WBACK;
        end
        S_WBACK: begin
          res_q   <= alu_v;
          res_c_q <= alu_c;
          state   <= S_WRITE;
        end
        S_WRITE: begin
          flag_n <= res_q[7];
          flag_z <= (res_q == 8'd0);
          flag_c <= res_c_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign addr  = (state == S_IDLE || state == S_LO || state == S_HI) ? pc_q : {hi_q, lo_q};
  assign we    = (state == S_WBACK) || (state == S_WRITE);
  assign wdata = (state == S_WRITE) ? res_q : opnd_q;
  assign done  = (state == S_WRITE);
  assign pc    = pc_q;

endmodule

// File: rtl/rmw_absx_seq_sva.sv
module rmw_absx_seq_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        we,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [15:0] pc,
  input logic        done
);

  a_r5_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we) |=> (we && done));

  a_r5_wback_unmodified: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !done) |-> (wdata == $past(rdata)));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (addr == $past(addr)));

  a_r8_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> we);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !we));

  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc == $past(pc, 6) + 16'd3));

endmodule

bind rmw_absx_seq rmw_absx_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .rdata(rdata), .pc(pc), .done(done)
);

// File: tb/rmw_absx_seq_tb.sv
`timescale 1ns/1ps
module rmw_absx_seq_tb;
  localparam logic [15:0] START_PC = 16'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [7:0]  x_idx = '0;
  logic        c_in = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] addr, pc;
  logic        we, done, flag_n, flag_z, flag_c;
  logic [7:0]  wdata;

  logic [15:0] g_pc0 = START_PC;
  logic [15:0] g_eff = 16'h0000;
  logic [7:0]  g_lo = '0, g_hi = '0, g_val = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rmw_absx_seq #(.RESET_PC(START_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .x_idx(x_idx),
    .c_in(c_in), .rdata(rdata), .addr(addr), .we(we), .wdata(wdata), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .done(done)
  );

  function automatic logic [7:0] junk(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rdata = (addr == g_pc0 + 16'd1) ? g_lo :
                 (addr == g_pc0 + 16'd2) ? g_hi :
                 (addr == g_eff)         ? g_val : junk(addr);

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    if (a == g_pc0 + 16'd1) return g_lo;
    if (a == g_pc0 + 16'd2) return g_hi;
    if (a == g_eff) return g_val;
    return junk(a);
  endfunction

  function automatic logic [8:0] model(input logic [2:0] op, input logic [7:0] v, input logic c);
    case (op)
      3'd0: return {v[7], v[6:0], 1'b0};
      3'd1: return {v[0], 1'b0, v[7:1]};
      3'd2: return {v[7], v[6:0], c};
      3'd3: return {v[0], c, v[7:1]};
      3'd4: return {c, 8'(v + 8'd1)};
      3'd5: return {c, 8'(v - 8'd1)};
      default: return {c, v};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(input logic [2:0] op, input logic [7:0] x, input logic c,
                         input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] val,
                         input bit poke);
    logic [8:0]  sum;
    logic [15:0] dummy, eff;
    logic [7:0]  opnd;
    logic [8:0]  r;
    sum   = {1'b0, lo} + {1'b0, x};
    dummy = {hi, sum[7:0]};
    eff   = {8'(hi + {7'd0, sum[8]}), sum[7:0]};
    g_lo = lo; g_hi = hi; g_val = val; g_eff = eff;
    opnd = mem_at(eff);
    r    = model(op, opnd, c);
    chk(addr == g_pc0 && !we, "R2 cycle1 opcode fetch", {15'd0, we, addr}, {16'd0, g_pc0});
    start = 1'b1; op_sel = op; x_idx = x; c_in = c;
    step();
    start = poke;
    op_sel = 3'($urandom); x_idx = 8'($urandom); c_in = 1'($urandom);
    chk(addr == g_pc0 + 16'd1 && !we, "R2 R10 R11 cycle2 low byte fetch", {16'd0, addr}, {16'd0, 16'(g_pc0 + 16'd1)});
    step();
    chk(addr == g_pc0 + 16'd2 && !we, "R2 cycle3 high byte fetch", {16'd0, addr}, {16'd0, 16'(g_pc0 + 16'd2)});
    step();
    chk(addr == dummy && !we, "R3 cycle4 uncorrected read", {16'd0, addr}, {16'd0, dummy});
    step();
    chk(addr == eff && !we, "R4 cycle5 operand read", {16'd0, addr}, {16'd0, eff});
    step();
    chk(addr == eff && we && !done, "R4 R5 cycle6 write strobe", {14'd0, we, done, addr}, {14'd2, eff});
    chk(wdata == opnd, "R5 cycle6 unmodified write-back", {24'd0, wdata}, {24'd0, opnd});
    step();
    chk(addr == eff && we && done, "R4 R8 cycle7 final write", {14'd0, we, done, addr}, {14'd3, eff});
    chk(wdata == r[7:0], "R6 R11 cycle7 result", {24'd0, wdata}, {24'd0, r[7:0]});
    step();
    start = 1'b0;
    chk(addr == g_pc0 + 16'd3 && pc == g_pc0 + 16'd3, "R9 next opcode address", {pc, addr}, {2{16'(g_pc0 + 16'd3)}});
    chk(!we && !done, "R5 R8 idle after instruction", {30'd0, we, done}, 32'd0);
    chk({flag_n, flag_z, flag_c} == {r[7], r[7:0] == 8'd0, r[8]}, "R7 flags",
        {29'd0, flag_n, flag_z, flag_c}, {29'd0, r[7], r[7:0] == 8'd0, r[8]});
    g_pc0 = g_pc0 + 16'd3;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(addr == START_PC && pc == START_PC, "R1 reset address", {pc, addr}, {START_PC, START_PC});
    chk(!we && !done && !flag_n && !flag_z && !flag_c, "R1 reset outputs",
        {27'd0, we, done, flag_n, flag_z, flag_c}, 32'd0);
    step();
    chk(addr == START_PC, "R1 idle holds without start", {16'd0, addr}, {16'd0, START_PC});
    // directed corners
    run_one(3'd0, 8'h01, 1'b0, 8'hFF, 8'h12, 8'h80, 1'b0); // page cross, shift sets C and Z
    run_one(3'd1, 8'h00, 1'b1, 8'h34, 8'h20, 8'h01, 1'b1); // no carry, x=0
    run_one(3'd2, 8'h10, 1'b1, 8'hF8, 8'hFF, 8'h7F, 1'b1); // high byte wraps to 00
    run_one(3'd3, 8'hFF, 1'b1, 8'hFF, 8'h40, 8'h00, 1'b0);
    run_one(3'd4, 8'h05, 1'b1, 8'h00, 8'h30, 8'hFF, 1'b0); // inc to zero keeps C
    run_one(3'd5, 8'h05, 1'b0, 8'h00, 8'h30, 8'h00, 1'b1); // dec to FF
    run_one(3'd6, 8'h80, 1'b1, 8'h80, 8'h55, 8'hA5, 1'b0); // pass-through
    run_one(3'd7, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1);
    for (int i = 0; i < 300; i++)
      run_one(3'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule